// File: doc/BRIEF.md
# Address Remap Window Decoder

This block decides whether a 36-bit physical address falls inside a single programmable window and, when it does, moves the address by a fixed relocation distance. The window is set by two 10-bit fields, a lower block number and an upper block number, each counting 64 MB blocks. The lower edge is the first byte of the lower block. The upper edge is the last byte of the upper block, so the window is inclusive at both ends. If the upper block number is below the lower one, the window is off and nothing hits.

Configuration goes through a narrow 16-bit register port with a select line that picks one of the two fields. A lock input freezes both fields until the next reset, so the window cannot be moved after it has been set up. Every cycle the decoder takes one address and, one clock later, gives a registered hit flag and a registered output address. The output address is the input plus the relocation offset on a hit, and the input unchanged on a miss.

Top module: `remap_window_dec`

## Requirements
- R1: After a synchronous reset, both fields read as zero, the lock is clear, and `hit_o` and `addr_o` are zero. Because both fields are zero, the window then covers addresses 0x0_0000_0000 to 0x0_03FF_FFFF.
- R2: A cycle with `cfg_wr_en` high writes `cfg_wr_data[9:0]` into the field chosen by `cfg_wr_sel` (0 selects the lower block, 1 selects the upper block), provided the block is not locked. `cfg_rd_data` shows the field chosen by `cfg_rd_sel` (same encoding) in bits [9:0], with bits [15:10] always zero.
- R3: The lower bound is inclusive. An address whose bits [35:26] equal the lower field can hit. An address one byte below that block does not hit.
- R4: The upper bound is inclusive, with the low 26 bits taken as all ones. Address {upper, 26'h3FFFFFF} can hit, and address {upper+1, 26'h0} does not.
- R5: When the upper field is below the lower field, no address hits.
- R6: A write is ignored in any cycle where `cfg_lock` is high or has been high at any earlier clock edge since reset. The lock stays set until reset.
- R7: `hit_o` and `addr_o` reflect the address presented on `addr_in` before the previous rising clock edge. They do not change between edges.
- R8: On a hit, `addr_o` equals `addr_in` plus OFS_BLK × 64 MB, modulo 2^36 (the default OFS_BLK is 16, which is 1 GB). On a miss, `addr_o` equals `addr_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Field write strobe |
| cfg_wr_sel | input | 1 | Write target: 0 lower field, 1 upper field |
| cfg_wr_data | input | 16 | Write word; only bits [9:0] are stored |
| cfg_lock | input | 1 | Freezes both fields until reset |
| cfg_rd_sel | input | 1 | Read source: 0 lower field, 1 upper field |
| cfg_rd_data | output | 16 | Selected field, zero-extended |
| addr_in | input | 36 | Address to decode |
| hit_o | output | 1 | Registered window hit |
| addr_o | output | 36 | Registered output address, relocated on a hit |

## Verification
The decoder is tried with addresses that sit exactly on the lower block edge and one byte below it. This tells an inclusive lower compare apart from an exclusive one. It is also tried on the last byte of the upper block and the first byte of the block after it, which shows whether the low 26 bits of the upper bound are filled with ones and whether the upper compare is inclusive. Other patterns are:
- a single-block window, where both fields are equal;
- an inverted window, probed at both of its field values;
- a full-range window;
- a hit in the top block, whose relocation must wrap modulo 2^36.

Lock tests write during the cycle the lock is raised and again after it is released, and check that the fields hold. A latency probe checks the outputs just before and just after the capturing edge.

// File: rtl/remap_pkg.sv
package remap_pkg;

    localparam int ADDR_W = 36;
    localparam int GRAN_W = 26;
    localparam int FLD_W  = ADDR_W - GRAN_W;
    localparam int REG_W  = 16;

    typedef enum logic {
        SEL_LOWER = 1'b0,
        SEL_UPPER = 1'b1
    } fld_sel_e;

    typedef struct packed {
        logic [FLD_W-1:0] lower;
        logic [FLD_W-1:0] upper;
    } window_t;

    // first byte covered by the lower block
    function automatic logic [ADDR_W-1:0] win_floor(input logic [FLD_W-1:0] blk);
        return {blk, {GRAN_W{1'b0}}};
    endfunction

    // last byte covered by the upper block
    function automatic logic [ADDR_W-1:0] win_ceil(input logic [FLD_W-1:0] blk);
        return {blk, {GRAN_W{1'b1}}};
    endfunction

    function automatic logic [REG_W-1:0] zext_fld(input logic [FLD_W-1:0] f);
        return {{(REG_W-FLD_W){1'b0}}, f};
    endfunction

endpackage

// File: rtl/remap_cfg_regs.sv
module remap_cfg_regs
    import remap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  fld_sel_e         wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             lock_in,
    input  fld_sel_e         rd_sel,
    output logic [REG_W-1:0] rd_data,
    output window_t          win
);

    window_t win_q;
    logic    lock_q;
    logic    wr_ok;

    assign wr_ok = wr_en && !lock_q && !lock_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q  <= '0;
            lock_q <= 1'b0;
        end else begin
            lock_q <= lock_q | lock_in;
            if (wr_ok) begin
                if (wr_sel == SEL_UPPER) win_q.upper <= wr_data[FLD_W-1:0];
                else                     win_q.lower <= wr_data[FLD_W-1:0];
            end
        end
    end

    always_comb begin
        rd_data = zext_fld((rd_sel == SEL_UPPER) ? win_q.upper : win_q.lower);
    end

    assign win = win_q;

    // R6: once locked, the lock never clears before reset
    assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> lock_q);

    // R6: fields are frozen while locked
    assert_lock_freeze_R6: assert property (@(posedge clk) disable iff (rst)
        (lock_q || lock_in) |=> $stable(win_q));

endmodule

// File: rtl/remap_win_cmp.sv
module remap_win_cmp
    import remap_pkg::*;
(
    input  window_t           win,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    logic enabled;
    logic above_floor;
    logic below_ceil;

    always_comb begin
        enabled     = (win.upper >= win.lower);
        above_floor = (addr >= win_floor(win.lower));
        below_ceil  = (addr <= win_ceil(win.upper));
        hit         = enabled && above_floor && below_ceil;
    end

endmodule

// File: rtl/remap_reloc_out.sv
module remap_reloc_out
    import remap_pkg::*;
#(
    parameter int OFS_BLK = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit_c,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_q,
    output logic [ADDR_W-1:0] addr_q
);

    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(OFS_BLK) << GRAN_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            hit_q  <= hit_c;
            addr_q <= hit_c ? (addr + OFS) : addr;
        end
    end

endmodule

// File: rtl/remap_window_dec.sv
module remap_window_dec
    import remap_pkg::*;
#(
    parameter int OFS_BLK = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_wr_en,
    input  logic                 cfg_wr_sel,
    input  logic [REG_W-1:0]     cfg_wr_data,
    input  logic                 cfg_lock,
    input  logic                 cfg_rd_sel,
    output logic [REG_W-1:0]     cfg_rd_data,
    input  logic [ADDR_W-1:0]    addr_in,
    output logic                 hit_o,
    output logic [ADDR_W-1:0]    addr_o
);

    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(OFS_BLK) << GRAN_W;

    window_t win;
    logic    hit_c;

    remap_cfg_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .wr_sel  (fld_sel_e'(cfg_wr_sel)),
        .wr_data (cfg_wr_data),
        .lock_in (cfg_lock),
        .rd_sel  (fld_sel_e'(cfg_rd_sel)),
        .rd_data (cfg_rd_data),
        .win     (win)
    );

    remap_win_cmp u_cmp (
        .win  (win),
        .addr (addr_in),
        .hit  (hit_c)
    );

    remap_reloc_out #(.OFS_BLK(OFS_BLK)) u_out (
        .clk    (clk),
        .rst    (rst),
        .hit_c  (hit_c),
        .addr   (addr_in),
        .hit_q  (hit_o),
        .addr_q (addr_o)
    );

    // R5: an inverted window never yields a hit on the next cycle
    assert_inverted_nohit_R5: assert property (@(posedge clk) disable iff (rst)
        (win.upper < win.lower) |=> !hit_o);

    // R4: a hit never lies above the upper block
    assert_upper_bound_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (!hit_o || ($past(addr_in[ADDR_W-1:GRAN_W]) <= $past(win.upper))));

    // R3: a hit never lies below the lower block
    assert_lower_bound_R3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (!hit_o || ($past(addr_in[ADDR_W-1:GRAN_W]) >= $past(win.lower))));

    // R8: output differs from the presented address by the offset or not at all
    assert_reloc_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((addr_o - $past(addr_in)) == (hit_o ? OFS : '0)));

endmodule

// File: tb/remap_window_dec_tb_top.sv
module remap_window_dec_tb_top;

    localparam int AW = 36;
    localparam int OFS_BLK = 16;
    localparam logic [AW-1:0] OFS = AW'(OFS_BLK) << 26;
    localparam int NV = 10;

    // {exp_hit, lower, upper, addr}
    localparam logic [56:0] VEC [NV] = '{
        {1'b1, 10'h004, 10'h007, {10'h004, 26'h0000000}},
        {1'b0, 10'h004, 10'h007, {10'h003, 26'h3FFFFFF}},
        {1'b1, 10'h004, 10'h007, {10'h007, 26'h3FFFFFF}},
        {1'b0, 10'h004, 10'h007, {10'h008, 26'h0000000}},
        {1'b1, 10'h005, 10'h005, {10'h005, 26'h1234567}},
        {1'b0, 10'h009, 10'h008, {10'h008, 26'h0000000}},
        {1'b0, 10'h009, 10'h008, {10'h009, 26'h0000000}},
        {1'b1, 10'h3FF, 10'h3FF, {10'h3FF, 26'h0000ABC}},
        {1'b1, 10'h000, 10'h3FF, 36'h123456789},
        {1'b0, 10'h200, 10'h1FF, {10'h200, 26'h0000000}}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_wr_en = 1'b0;
    logic          cfg_wr_sel = 1'b0;
    logic [15:0]   cfg_wr_data = '0;
    logic          cfg_lock = 1'b0;
    logic          cfg_rd_sel = 1'b0;
    logic [15:0]   cfg_rd_data;
    logic [AW-1:0] addr_in = '0;
    logic          hit_o;
    logic [AW-1:0] addr_o;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    remap_window_dec #(.OFS_BLK(OFS_BLK)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_sel  (cfg_wr_sel),
        .cfg_wr_data (cfg_wr_data),
        .cfg_lock    (cfg_lock),
        .cfg_rd_sel  (cfg_rd_sel),
        .cfg_rd_data (cfg_rd_data),
        .addr_in     (addr_in),
        .hit_o       (hit_o),
        .addr_o      (addr_o)
    );

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [15:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [15:0] v);
        cfg_rd_sel = sel;
        #0.1;
        v = cfg_rd_data;
    endtask

    task automatic present(input logic [AW-1:0] a);
        @(negedge clk);
        addr_in = a;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] rv;
        logic [AW-1:0] exp_a;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 hit_o", AW'(hit_o), '0);
        chk("R1 addr_o", addr_o, '0);
        rd(1'b0, rv); chk("R1 lower", AW'(rv), '0);
        rd(1'b1, rv); chk("R1 upper", AW'(rv), '0);
        present(36'h0_0000_0010);
        chk("R1 default window hit", AW'(hit_o), 1);
        chk("R1 default window addr", addr_o, 36'h0_0000_0010 + OFS);

        // R2 readback zero-extends
        wr(1'b1, 16'hFC05);
        rd(1'b1, rv); chk("R2 upper readback", AW'(rv), 36'h005);
        wr(1'b0, 16'h8003);
        rd(1'b0, rv); chk("R2 lower readback", AW'(rv), 36'h003);

        // R7 latency: window [3,5]; miss then hit
        present(36'h0_0000_0000);
        chk("R7 prior miss", AW'(hit_o), 0);
        @(negedge clk);
        addr_in = {10'h004, 26'h0};
        #1;
        chk("R7 before edge", AW'(hit_o), 0);
        @(negedge clk);
        chk("R7 after edge", AW'(hit_o), 1);

        // vector table: R3 R4 R5 R8
        for (int i = 0; i < NV; i++) begin
            logic e_hit;
            logic [AW-1:0] a;
            e_hit = VEC[i][56];
            a = VEC[i][35:0];
            wr(1'b0, {6'b0, VEC[i][55:46]});
            wr(1'b1, {6'b0, VEC[i][45:36]});
            present(a);
            exp_a = e_hit ? a + OFS : a;
            chk($sformatf("R3/R4/R5 vec%0d hit", i), AW'(hit_o), AW'(e_hit));
            chk($sformatf("R8 vec%0d addr", i), addr_o, exp_a);
        end

        // R6 lock
        wr(1'b0, 16'h00AA);
        wr(1'b1, 16'h00BB);
        @(negedge clk);
        cfg_lock = 1'b1; cfg_wr_en = 1'b1; cfg_wr_sel = 1'b0; cfg_wr_data = 16'h0011;
        @(negedge clk);
        cfg_lock = 1'b0; cfg_wr_en = 1'b0;
        rd(1'b0, rv); chk("R6 write with lock ignored", AW'(rv), 36'h0AA);
        wr(1'b1, 16'h0022);
        rd(1'b1, rv); chk("R6 sticky lock upper", AW'(rv), 36'h0BB);
        wr(1'b0, 16'h0001);
        rd(1'b0, rv); chk("R6 sticky lock lower", AW'(rv), 36'h0AA);
        present({10'h0BB, 26'h3FFFFFF});
        chk("R6 locked window hit", AW'(hit_o), 1);
        present({10'h022, 26'h0});
        chk("R6 locked window miss", AW'(hit_o), 0);
        chk("R8 miss passthrough", addr_o, {10'h022, 26'h0});

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule